// File: doc/BRIEF.md
# TLB Invalidate-by-Address Access Checker

This block decides what happens when software issues one particular TLB maintenance operation: invalidate by virtual address across every address-space identifier, for the level-1 translation regime. It comes in two forms. The plain form invalidates all matching entries. The filtered form leaves out entries that carry the marked (slow-completion) memory attribute. The block receives the decoded system-operation fields, the current privilege level (0 to 3), a set of feature-present flags, the hypervisor-enable state and the trap-control bits. From these it produces one registered verdict for each request.

The verdict is one of four outcomes. It is undefined, a trap to privilege level 2 with exception class 0x18, a silent no-operation, or an issued invalidation. An issued invalidation carries its scope: the translation regime, the current VMID, the sharing domain, the walk level and the attribute filter. An encoding that matches neither form gives the result "not handled". In that case the result strobe is raised and all four outcome flags are low, which is distinct from undefined.

Requests use a valid/ready handshake. A request is accepted on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is low while reset is applied and on the first edge after reset. It is high from then on, because the result path has no back-pressure. A requester that sees `in_ready` low must hold its request.

Top module: `tlbchk_top`

## Requirements
- R1: Only two encodings are recognised: (op0,op1,CRn,CRm,op2) = (01,000,1000,0111,011) for the plain form, and the same fields with CRn=1001 for the filtered form. Any other encoding gives `out_valid`=1 with `out_undef`, `out_trap`, `out_nop` and `out_issue` all 0.
- R2: When `wide_arch_present`=0, both forms give undefined. When `marked_attr_present`=0, the filtered form gives undefined. These checks come before any level-based check.
- R3: At privilege level 0, a recognised form gives undefined.
- R4: At level 1, if `hyp_enabled`=1 and `hyp_tlb_trap`=1, the result is a trap. This check comes before every other level-1 check. `out_syndrome` is 6'h18 whenever `out_trap`=1 and 0 otherwise.
- R5: At level 1, the plain form traps when all of the following hold: `hyp_enabled`=1, `fg_trap_present`=1, either `top_level_present`=0 or `top_fg_enable`=1, and `fg_inv_trap`=1. If no trap applies, the invalidation is issued.
- R6: For the filtered form, the level-1 fine-grained trap of R5 also needs `xctl_present`=1, and either `xctl_enable`=0 or `xctl_fg_marked`=0.
- R7: At level 2, a recognised form that is not undefined under R2 is always issued. No trap control has any effect there.
- R8: At level 3, the result is a no-operation when `realm_present`=1 and `lvl1_sec_valid`=0. Otherwise the invalidation is issued.
- R9: An issued invalidation drives the following scope fields:
  - `out_regime`=2'd1 (level-1 regime);
  - `out_vmid`=`vmid`, as captured with the request;
  - `out_share`=2'd0 (non-shareable);
  - `out_walk_lvl`=2'd0 (any level);
  - `out_filter`=0 for the plain form and 1 for the filtered form.

  All of these fields are 0 in any result that is not an issue.
- R10: A request accepted on an edge gives `out_valid`=1 after exactly that edge, for one cycle. At most one outcome flag is high, and only while `out_valid`=1. A request presented while `in_ready`=0 gives no result.
- R11: While reset is applied, `out_valid`, all outcome flags and `in_ready` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be accepted |
| in_op0 | input | 2 | Encoding field op0 |
| in_op1 | input | 3 | Encoding field op1 |
| in_crn | input | 4 | Encoding field CRn |
| in_crm | input | 4 | Encoding field CRm |
| in_op2 | input | 3 | Encoding field op2 |
| in_level | input | 2 | Current privilege level |
| vmid | input | VMID_W | Current virtual machine identifier |
| wide_arch_present | input | 1 | 64-bit architecture implemented |
| marked_attr_present | input | 1 | Marked memory attribute implemented |
| fg_trap_present | input | 1 | Fine-grained traps implemented |
| xctl_present | input | 1 | Extended hypervisor control implemented |
| realm_present | input | 1 | Realm management implemented |
| top_level_present | input | 1 | Privilege level 3 implemented |
| hyp_enabled | input | 1 | Level 2 enabled for the current state |
| hyp_tlb_trap | input | 1 | Trap all TLB maintenance from level 1 |
| top_fg_enable | input | 1 | Level-3 enable for fine-grained traps |
| fg_inv_trap | input | 1 | Fine-grained trap bit for this operation |
| xctl_enable | input | 1 | Extended control register in use |
| xctl_fg_marked | input | 1 | Extended control: filtered forms skip fine-grained trap |
| lvl1_sec_valid | input | 1 | Security state of level 1 is valid |
| out_valid | output | 1 | Result strobe, one cycle |
| out_undef | output | 1 | Outcome: undefined |
| out_trap | output | 1 | Outcome: trap to level 2 |
| out_nop | output | 1 | Outcome: silent no-operation |
| out_issue | output | 1 | Outcome: invalidation issued |
| out_syndrome | output | 6 | Exception class for a trap |
| out_regime | output | 2 | Translation regime of the invalidation |
| out_vmid | output | VMID_W | VMID of the invalidation |
| out_share | output | 2 | Sharing domain of the invalidation |
| out_walk_lvl | output | 2 | Walk-level hint of the invalidation |
| out_filter | output | 1 | Attribute filter: 1 excludes marked entries |

## Verification
The properties assume that the encoding fields, privilege level and control flags hold known 0/1 values whenever `in_valid` is high. They also assume that the control flags describe the same request as the encoding they accompany, since the checker reads them on the accepting edge. The stimulus meets both assumptions by driving every input as a whole vector on the falling edge, with no X or Z, and by sweeping all 13 control flags against every level and against two recognised and two near-miss encodings. The properties also assume `rst_n` is synchronous; the bench changes reset only away from the rising edge.

// File: rtl/tlbchk_pkg.sv
package tlbchk_pkg;

  typedef enum logic [1:0] {
    FORM_NONE  = 2'd0,
    FORM_PLAIN = 2'd1,
    FORM_EXCL  = 2'd2
  } form_e;

  typedef enum logic [2:0] {
    VERD_NONE  = 3'd0,
    VERD_UNDEF = 3'd1,
    VERD_TRAP  = 3'd2,
    VERD_NOP   = 3'd3,
    VERD_ISSUE = 3'd4
  } verdict_e;

  typedef struct packed {
    logic wide_arch;
    logic marked_attr;
    logic fg_impl;
    logic xctl_impl;
    logic realm;
    logic top_present;
    logic hyp_en;
    logic hyp_tlb_trap;
    logic top_fg_en;
    logic fg_bit;
    logic xctl_en;
    logic xctl_fg_marked;
    logic sec_valid;
  } ctrl_t;

  localparam logic [1:0] ENC_OP0     = 2'b01;
  localparam logic [2:0] ENC_OP1     = 3'b000;
  localparam logic [3:0] ENC_CRN_PL  = 4'b1000;
  localparam logic [3:0] ENC_CRN_EX  = 4'b1001;
  localparam logic [3:0] ENC_CRM     = 4'b0111;
  localparam logic [2:0] ENC_OP2     = 3'b011;

  localparam logic [5:0] SYND_TRAP   = 6'h18;
  localparam logic [1:0] REGIME_L10  = 2'd1;
  localparam logic [1:0] SHARE_LOCAL = 2'd0;
  localparam logic [1:0] WALK_ANY    = 2'd0;

endpackage

// File: rtl/tlbchk_decode.sv
module tlbchk_decode
  import tlbchk_pkg::*;
(
  input  logic [1:0] op0,
  input  logic [2:0] op1,
  input  logic [3:0] crn,
  input  logic [3:0] crm,
  input  logic [2:0] op2,
  output form_e      form
);
  logic common_hit;

  // Every field except CRn is shared by both forms
  assign common_hit = (op0 == ENC_OP0) && (op1 == ENC_OP1) &&
                      (crm == ENC_CRM) && (op2 == ENC_OP2);

  always_comb begin
    form = FORM_NONE;
    if (common_hit) begin
      if (crn == ENC_CRN_PL)      form = FORM_PLAIN;
      else if (crn == ENC_CRN_EX) form = FORM_EXCL;
    end
  end
endmodule

// File: rtl/tlbchk_policy.sv
module tlbchk_policy
  import tlbchk_pkg::*;
(
  input  form_e      form,
  input  logic [1:0] level,
  input  ctrl_t      ctrl,
  output verdict_e   verdict,
  output logic       filter
);
  logic fg_common;
  logic fg_excl_gate;
  logic fg_hit;
  logic feat_ok;

  // Fine-grained trap: terms shared by both forms
  assign fg_common = ctrl.hyp_en && ctrl.fg_impl &&
                     (!ctrl.top_present || ctrl.top_fg_en) && ctrl.fg_bit;

  // Filtered form: extended control must exist and must not waive the trap
  assign fg_excl_gate = ctrl.xctl_impl && (!ctrl.xctl_en || !ctrl.xctl_fg_marked);

  assign fg_hit = fg_common && ((form != FORM_EXCL) || fg_excl_gate);

  assign feat_ok = ctrl.wide_arch && ((form != FORM_EXCL) || ctrl.marked_attr);

  always_comb begin
    verdict = VERD_NONE;
    filter  = 1'b0;
    if (form != FORM_NONE) begin
      filter = (form == FORM_EXCL);
      if (!feat_ok) begin
        verdict = VERD_UNDEF;
      end else begin
        unique case (level)
          2'd0: verdict = VERD_UNDEF;
          2'd1: begin
            if (ctrl.hyp_en && ctrl.hyp_tlb_trap) verdict = VERD_TRAP;
            else if (fg_hit)                      verdict = VERD_TRAP;
            else                                  verdict = VERD_ISSUE;
          end
          2'd2: verdict = VERD_ISSUE;
          default: begin
            if (ctrl.realm && !ctrl.sec_valid) verdict = VERD_NOP;
            else                               verdict = VERD_ISSUE;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/tlbchk_outreg.sv
module tlbchk_outreg
  import tlbchk_pkg::*;
#(
  parameter int VMID_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  verdict_e          verdict,
  input  logic              filter,
  input  logic [VMID_W-1:0] vmid,
  output logic              out_valid,
  output logic              out_undef,
  output logic              out_trap,
  output logic              out_nop,
  output logic              out_issue,
  output logic [5:0]        out_syndrome,
  output logic [1:0]        out_regime,
  output logic [VMID_W-1:0] out_vmid,
  output logic [1:0]        out_share,
  output logic [1:0]        out_walk_lvl,
  output logic              out_filter
);
  logic is_issue;
  assign is_issue = (verdict == VERD_ISSUE);

  always_ff @(posedge clk) begin
    if (!rst_n || !accept) begin
      out_valid    <= 1'b0;
      out_undef    <= 1'b0;
      out_trap     <= 1'b0;
      out_nop      <= 1'b0;
      out_issue    <= 1'b0;
      out_syndrome <= '0;
      out_regime   <= '0;
      out_vmid     <= '0;
      out_share    <= '0;
      out_walk_lvl <= '0;
      out_filter   <= 1'b0;
    end else begin
      out_valid    <= 1'b1;
      out_undef    <= (verdict == VERD_UNDEF);
      out_trap     <= (verdict == VERD_TRAP);
      out_nop      <= (verdict == VERD_NOP);
      out_issue    <= is_issue;
      out_syndrome <= (verdict == VERD_TRAP) ? SYND_TRAP : 6'd0;
      out_regime   <= is_issue ? REGIME_L10  : 2'd0;
      out_vmid     <= is_issue ? vmid        : '0;
      out_share    <= is_issue ? SHARE_LOCAL : 2'd0;
      out_walk_lvl <= is_issue ? WALK_ANY    : 2'd0;
      out_filter   <= is_issue ? filter      : 1'b0;
    end
  end
endmodule

// File: rtl/tlbchk_top.sv
module tlbchk_top
  import tlbchk_pkg::*;
#(
  parameter int VMID_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_op0,
  input  logic [2:0]        in_op1,
  input  logic [3:0]        in_crn,
  input  logic [3:0]        in_crm,
  input  logic [2:0]        in_op2,
  input  logic [1:0]        in_level,
  input  logic [VMID_W-1:0] vmid,
  input  logic              wide_arch_present,
  input  logic              marked_attr_present,
  input  logic              fg_trap_present,
  input  logic              xctl_present,
  input  logic              realm_present,
  input  logic              top_level_present,
  input  logic              hyp_enabled,
  input  logic              hyp_tlb_trap,
  input  logic              top_fg_enable,
  input  logic              fg_inv_trap,
  input  logic              xctl_enable,
  input  logic              xctl_fg_marked,
  input  logic              lvl1_sec_valid,
  output logic              out_valid,
  output logic              out_undef,
  output logic              out_trap,
  output logic              out_nop,
  output logic              out_issue,
  output logic [5:0]        out_syndrome,
  output logic [1:0]        out_regime,
  output logic [VMID_W-1:0] out_vmid,
  output logic [1:0]        out_share,
  output logic [1:0]        out_walk_lvl,
  output logic              out_filter
);
  form_e    form;
  verdict_e verdict;
  logic     filter;
  ctrl_t    ctrl;
  logic     ready_q;
  logic     accept;

  // Ready rises one edge after reset; no back-pressure from the result side
  always_ff @(posedge clk) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end
  assign in_ready = ready_q;
  assign accept   = in_valid && ready_q;

  always_comb begin
    ctrl.wide_arch      = wide_arch_present;
    ctrl.marked_attr    = marked_attr_present;
    ctrl.fg_impl        = fg_trap_present;
    ctrl.xctl_impl      = xctl_present;
    ctrl.realm          = realm_present;
    ctrl.top_present    = top_level_present;
    ctrl.hyp_en         = hyp_enabled;
    ctrl.hyp_tlb_trap   = hyp_tlb_trap;
    ctrl.top_fg_en      = top_fg_enable;
    ctrl.fg_bit         = fg_inv_trap;
    ctrl.xctl_en        = xctl_enable;
    ctrl.xctl_fg_marked = xctl_fg_marked;
    ctrl.sec_valid      = lvl1_sec_valid;
  end

  tlbchk_decode u_decode (
    .op0  (in_op0),
    .op1  (in_op1),
    .crn  (in_crn),
    .crm  (in_crm),
    .op2  (in_op2),
    .form (form)
  );

  tlbchk_policy u_policy (
    .form    (form),
    .level   (in_level),
    .ctrl    (ctrl),
    .verdict (verdict),
    .filter  (filter)
  );

  tlbchk_outreg #(.VMID_W(VMID_W)) u_outreg (
    .clk          (clk),
    .rst_n        (rst_n),
    .accept       (accept),
    .verdict      (verdict),
    .filter       (filter),
    .vmid         (vmid),
    .out_valid    (out_valid),
    .out_undef    (out_undef),
    .out_trap     (out_trap),
    .out_nop      (out_nop),
    .out_issue    (out_issue),
    .out_syndrome (out_syndrome),
    .out_regime   (out_regime),
    .out_vmid     (out_vmid),
    .out_share    (out_share),
    .out_walk_lvl (out_walk_lvl),
    .out_filter   (out_filter)
  );
endmodule

// File: rtl/tlbchk_props.sv
module tlbchk_props #(
  parameter int VMID_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [1:0]        in_op0,
  input logic [2:0]        in_op1,
  input logic [3:0]        in_crn,
  input logic [3:0]        in_crm,
  input logic [2:0]        in_op2,
  input logic [1:0]        in_level,
  input logic              wide_arch_present,
  input logic              marked_attr_present,
  input logic              realm_present,
  input logic              lvl1_sec_valid,
  input logic              out_valid,
  input logic              out_undef,
  input logic              out_trap,
  input logic              out_nop,
  input logic              out_issue,
  input logic [5:0]        out_syndrome,
  input logic [1:0]        out_regime,
  input logic [VMID_W-1:0] out_vmid,
  input logic [1:0]        out_share,
  input logic [1:0]        out_walk_lvl,
  input logic              out_filter
);
  logic hit_plain, hit_excl, hit_any;
  assign hit_plain = (in_op0 == 2'b01) && (in_op1 == 3'b000) && (in_crn == 4'b1000) &&
                     (in_crm == 4'b0111) && (in_op2 == 3'b011);
  assign hit_excl  = (in_op0 == 2'b01) && (in_op1 == 3'b000) && (in_crn == 4'b1001) &&
                     (in_crm == 4'b0111) && (in_op2 == 3'b011);
  assign hit_any   = hit_plain || hit_excl;

  assert_result_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  assert_no_result_unaccepted_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> !out_valid);

  assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out_undef, out_trap, out_nop, out_issue}));

  assert_flags_need_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !(out_undef || out_trap || out_nop || out_issue));

  assert_unmatched_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !hit_any) |=> (out_valid && !out_undef && !out_trap && !out_nop && !out_issue));

  assert_no_wide_arch_undef_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && hit_any && !wide_arch_present) |=> out_undef);

  assert_level0_undef_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && hit_any && in_level == 2'd0) |=> out_undef);

  assert_trap_syndrome_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_trap |-> (out_syndrome == 6'h18));

  assert_syndrome_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !out_trap |-> (out_syndrome == 6'd0));

  assert_level2_plain_issue_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && hit_plain && wide_arch_present && in_level == 2'd2)
      |=> (out_issue && !out_filter));

  assert_level2_excl_issue_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && hit_excl && wide_arch_present && marked_attr_present && in_level == 2'd2)
      |=> (out_issue && out_filter));

  assert_level3_nop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && hit_any && wide_arch_present && (hit_plain || marked_attr_present) &&
     in_level == 2'd3 && realm_present && !lvl1_sec_valid) |=> out_nop);

  assert_issue_scope_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_issue |-> (out_regime == 2'd1 && out_share == 2'd0 && out_walk_lvl == 2'd0));

  assert_scope_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_issue |-> (out_regime == 2'd0 && out_share == 2'd0 && out_vmid == '0 && !out_filter));
endmodule

bind tlbchk_top tlbchk_props #(.VMID_W(VMID_W)) u_props (
  .clk                 (clk),
  .rst_n               (rst_n),
  .in_valid            (in_valid),
  .in_ready            (in_ready),
  .in_op0              (in_op0),
  .in_op1              (in_op1),
  .in_crn              (in_crn),
  .in_crm              (in_crm),
  .in_op2              (in_op2),
  .in_level            (in_level),
  .wide_arch_present   (wide_arch_present),
  .marked_attr_present (marked_attr_present),
  .realm_present       (realm_present),
  .lvl1_sec_valid      (lvl1_sec_valid),
  .out_valid           (out_valid),
  .out_undef           (out_undef),
  .out_trap            (out_trap),
  .out_nop             (out_nop),
  .out_issue           (out_issue),
  .out_syndrome        (out_syndrome),
  .out_regime          (out_regime),
  .out_vmid            (out_vmid),
  .out_share           (out_share),
  .out_walk_lvl        (out_walk_lvl),
  .out_filter          (out_filter)
);

// File: tb/tb_tlbchk_top.sv
`timescale 1ns/1ps
module tb_tlbchk_top;
  localparam int VW = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, in_valid, in_ready;
  logic [1:0] in_op0, in_level;
  logic [2:0] in_op1, in_op2;
  logic [3:0] in_crn, in_crm;
  logic [VW-1:0] vmid;
  logic [12:0] cb;
  logic out_valid, out_undef, out_trap, out_nop, out_issue, out_filter;
  logic [5:0] out_syndrome;
  logic [1:0] out_regime, out_share, out_walk_lvl;
  logic [VW-1:0] out_vmid;

  int n_chk = 0;
  int n_bad = 0;

  tlbchk_top #(.VMID_W(VW)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op0(in_op0), .in_op1(in_op1), .in_crn(in_crn), .in_crm(in_crm), .in_op2(in_op2),
    .in_level(in_level), .vmid(vmid),
    .wide_arch_present(cb[0]), .marked_attr_present(cb[1]), .fg_trap_present(cb[2]),
    .xctl_present(cb[3]), .realm_present(cb[4]), .top_level_present(cb[5]),
    .hyp_enabled(cb[6]), .hyp_tlb_trap(cb[7]), .top_fg_enable(cb[8]),
    .fg_inv_trap(cb[9]), .xctl_enable(cb[10]), .xctl_fg_marked(cb[11]),
    .lvl1_sec_valid(cb[12]),
    .out_valid(out_valid), .out_undef(out_undef), .out_trap(out_trap), .out_nop(out_nop),
    .out_issue(out_issue), .out_syndrome(out_syndrome), .out_regime(out_regime),
    .out_vmid(out_vmid), .out_share(out_share), .out_walk_lvl(out_walk_lvl),
    .out_filter(out_filter)
  );

  // Expected result of one request: flags {undef,trap,nop,issue}, and the requirement that decides it
  logic [3:0] exp_flags;
  logic       exp_filter;
  string      exp_tag;

  task automatic model(input int form, input logic [1:0] lvl, input logic [12:0] c);
    bit excl, fg;
    excl = (form == 1);
    exp_filter = excl;
    if (form >= 2) begin
      exp_flags = 4'b0000; exp_tag = "R1";
    end else if (c[0] == 1'b0 || (excl && c[1] == 1'b0)) begin
      exp_flags = 4'b1000; exp_tag = "R2";
    end else if (lvl == 2'd0) begin
      exp_flags = 4'b1000; exp_tag = "R3";
    end else if (lvl == 2'd1) begin
      fg = c[6] & c[2] & (~c[5] | c[8]) & c[9];
      if (excl) fg = fg & c[3] & ~(c[10] & c[11]);
      if (c[6] & c[7]) begin
        exp_flags = 4'b0100; exp_tag = "R4";
      end else if (fg) begin
        exp_flags = 4'b0100; exp_tag = excl ? "R6" : "R5";
      end else begin
        exp_flags = 4'b0001; exp_tag = excl ? "R6" : "R5";
      end
    end else if (lvl == 2'd2) begin
      exp_flags = 4'b0001; exp_tag = "R7";
    end else begin
      exp_flags = (c[4] & ~c[12]) ? 4'b0010 : 4'b0001; exp_tag = "R8";
    end
  endtask

  logic [VW-1:0] prev_vmid;

  task automatic check_result();
    logic [3:0] got;
    got = {out_undef, out_trap, out_nop, out_issue};
    n_chk++;
    if (!out_valid || got != exp_flags) begin
      n_bad++;
      $display("FAIL %s: valid=%0b flags=%b expected valid=1 flags=%b", exp_tag, out_valid, got, exp_flags);
    end else if (out_syndrome != (exp_flags[2] ? 6'h18 : 6'd0)) begin
      n_bad++;
      $display("FAIL R4: syndrome=%h expected %h", out_syndrome, exp_flags[2] ? 6'h18 : 6'd0);
    end else if (exp_flags[0] &&
                 (out_regime != 2'd1 || out_vmid != prev_vmid || out_share != 2'd0 ||
                  out_walk_lvl != 2'd0 || out_filter != exp_filter)) begin
      n_bad++;
      $display("FAIL R9: scope=%0d/%h/%0d/%0d/%0b expected 1/%h/0/0/%0b",
               out_regime, out_vmid, out_share, out_walk_lvl, out_filter, prev_vmid, exp_filter);
    end else if (!exp_flags[0] &&
                 (out_regime != 0 || out_vmid != 0 || out_share != 0 || out_walk_lvl != 0 || out_filter)) begin
      n_bad++;
      $display("FAIL R9: scope not cleared, regime=%0d vmid=%h filter=%0b expected zeros",
               out_regime, out_vmid, out_filter);
    end
  endtask

  task automatic drive_form(input int form);
    in_op0 = 2'b01; in_op1 = 3'b000; in_crm = 4'b0111; in_op2 = 3'b011;
    case (form)
      0: in_crn = 4'b1000;
      1: in_crn = 4'b1001;
      2: in_crn = 4'b1010;
      default: begin in_crn = 4'b1000; in_op2 = 3'b010; end
    endcase
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b1; cb = '1; in_level = 2'd2; vmid = 16'h1234;
    drive_form(0);
    repeat (3) @(negedge clk);
    // R11: reset state while a request is offered
    n_chk++;
    if (out_valid || out_undef || out_trap || out_nop || out_issue || in_ready) begin
      n_bad++;
      $display("FAIL R11: valid=%0b flags=%b ready=%0b expected all 0",
               out_valid, {out_undef, out_trap, out_nop, out_issue}, in_ready);
    end
    rst_n = 1'b1;
    @(negedge clk);
    // R10: first edge after reset, ready was still low, so no result
    n_chk++;
    if (out_valid || !in_ready) begin
      n_bad++;
      $display("FAIL R10: valid=%0b ready=%0b expected valid=0 ready=1", out_valid, in_ready);
    end
    in_valid = 1'b0;
    @(negedge clk);
    n_chk++;
    if (out_valid) begin
      n_bad++;
      $display("FAIL R10: valid=%0b expected 0 with no request", out_valid);
    end

    // Full sweep: level, form, all 13 control flags; one request per cycle
    for (int i = 0; i < 4 * 4 * 8192; i++) begin
      logic [3:0] pf; logic pfilt; string ptag; logic [VW-1:0] pv;
      if (i > 0) check_result();
      in_valid = 1'b1;
      in_level = i[1:0];
      drive_form(int'(i[3:2]));
      cb       = i[16:4];
      vmid     = i[15:0] ^ 16'hA5C3;
      model(int'(i[3:2]), i[1:0], i[16:4]);
      pf = exp_flags; pfilt = exp_filter; ptag = exp_tag; pv = vmid;
      prev_vmid = pv;
      @(negedge clk);
      exp_flags = pf; exp_filter = pfilt; exp_tag = ptag;
    end
    check_result();
    in_valid = 1'b0;
    @(negedge clk);
    // R10: result lasts a single cycle
    n_chk++;
    if (out_valid) begin
      n_bad++;
      $display("FAIL R10: valid=%0b expected 0 after single result", out_valid);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule